// File: doc/BRIEF.md
# Triggered Acquisition Address Controller

The block runs one acquisition round into an external single-port SRAM. The SRAM is shared between the sampling path and a host processor. A trigger pulse from the host arms the round. The block then produces a sampling clock enable at half the master clock rate. For every valid merged data word it issues a write and steps the buffer address upward. The data words are ADC samples, zero-padded to the SRAM word width.

When the address counter wraps from its top value, the round is over. The block then gives the SRAM to the host: the address multiplexer selects the host's address, and the host-side tri-state data gate is enabled. A done flag stays high and an interrupt pulses for one cycle. The host reads the buffer at its own pace. It pulses a release input to return the block to idle, and only then will a new trigger be accepted.

Top module: `acq_round_ctrl`

## Requirements
- R1: After reset the block is idle: `done_o`, `irq_o`, `host_oe_o`, `sram_we_o` and `samp_ce_o` are 0 and `sram_addr_o` is 0. An asynchronous reset in the middle of a round also returns the block to this state.
- R2: A trigger sampled while idle arms the round. Sampling begins one cycle later. During the armed cycle, valid data produces no write.
- R3: `samp_ce_o` is high in the first armed cycle and then alternates high and low on every cycle while armed or sampling. It is 0 while idle or while the host owns the buffer.
- R4: While sampling, `sram_we_o` equals `smp_vld_i`. `sram_wdata_o` is always the sample zero-extended into the upper bits.
- R5: The address counter is 0 at the start of each round. It advances by one after each valid word written while sampling, and `sram_addr_o` shows it while the host does not own the buffer.
- R6: A valid word written at the top address ends the round. In the next cycle the host owns the buffer, `done_o` is 1, and `irq_o` is 1 for exactly that one cycle.
- R7: While the host owns the buffer, `sram_addr_o` equals `host_addr_i`, `host_oe_o` is 1, and `sram_we_o` stays 0 even with valid data.
- R8: While the host owns the buffer, a trigger has no effect. A release returns the block to idle and clears `done_o`. A trigger in the same cycle as the release is ignored.
- R9: A trigger while armed or sampling restarts the round: the counter returns to 0 and the block is armed again.
- R10: A release while the block is idle, armed or sampling has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Host trigger pulse |
| release_i | input | 1 | Host hands the buffer back |
| smp_vld_i | input | 1 | Merged sample word valid |
| smp_data_i | input | ADC_W | Merged sample word |
| host_addr_i | input | ADDR_W | Host read address |
| samp_ce_o | output | 1 | Sampling clock enable (master/2) |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | ADDR_W | SRAM address bus |
| sram_wdata_o | output | DATA_W | SRAM write data |
| host_oe_o | output | 1 | Enable of the host-side data gate |
| done_o | output | 1 | Round complete, host owns buffer |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives each pair together. First, a trigger and a release can arrive together while the host owns the buffer. The bench then checks that the block goes to idle with the counter address at 0 and no round armed. Second, a trigger can coincide with a valid word during sampling. The bench checks that the word is still written at the current address, and that the next cycle shows the armed state with address 0. The bench uses a small address width, so the wrap at the top address is reached and checked within a few cycles.

// File: rtl/acq_round_ctrl.sv
module acq_round_ctrl #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int ADC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              release_i,
  input  logic              smp_vld_i,
  input  logic [ADC_W-1:0]  smp_data_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic              samp_ce_o,
  output logic              sram_we_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  output logic              host_oe_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int PAD = DATA_W - ADC_W;
  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_SAMP, S_HOST} st_t;

  st_t               st;
  logic [ADDR_W-1:0] cnt;
  logic              phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      phase <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      case (st)
        S_IDLE: if (trig_i) begin
          st <= S_ARMED; cnt <= '0; phase <= 1'b1;
        end
        S_ARMED: if (trig_i) begin
          cnt <= '0; phase <= 1'b1;
        end else begin
          st <= S_SAMP; phase <= ~phase;
        end
        S_SAMP: if (trig_i) begin
          st <= S_ARMED; cnt <= '0; phase <= 1'b1;
        end else begin
          phase <= ~phase;
          if (smp_vld_i) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              st <= S_HOST; irq_o <= 1'b1;
            end
          end
        end
        S_HOST: if (release_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done_o       = (st == S_HOST);
  assign host_oe_o    = done_o;
  assign sram_addr_o  = done_o ? host_addr_i : cnt;
  assign sram_we_o    = (st == S_SAMP) && smp_vld_i;
  assign samp_ce_o    = ((st == S_ARMED) || (st == S_SAMP)) && phase;
  assign sram_wdata_o = {{PAD{1'b0}}, smp_data_i};

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  p_irq_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> irq_o);
  p_no_write_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe_o |-> !sram_we_o);
  p_ce_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ce_o && !trig_i) |=> !samp_ce_o);
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_o && !trig_i && sram_addr_o != LAST) |=>
      (sram_addr_o == $past(sram_addr_o) + 1'b1));
  p_trig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !release_i) |=> done_o);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !done_o) |=> (sram_addr_o == '0 && !sram_we_o));
endmodule

// File: tb/acq_round_ctrl_tb_top.sv
module acq_round_ctrl_tb_top;
  localparam int AW = 3, DW = 16, CW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 0, rel = 0, vld = 0;
  logic [CW-1:0] data = '0;
  logic [AW-1:0] haddr = '0;
  logic ce, we, hoe, done, irq;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  acq_round_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ADC_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .release_i(rel),
    .smp_vld_i(vld), .smp_data_i(data), .host_addr_i(haddr),
    .samp_ce_o(ce), .sram_we_o(we), .sram_addr_o(addr),
    .sram_wdata_o(wd), .host_oe_o(hoe), .done_o(done), .irq_o(irq));

  typedef struct packed {
    logic tr, rl, vl;
    logic [11:0] dt;
    logic [2:0] ha;
    logic we, dn, iq, oe, ce;
    logic [2:0] ad;
  } vec_t;

  // fields: trig rel vld data haddr | we done irq hoe ce addr
  localparam vec_t VEC [24] = '{
    '{0,0,0,12'h000,3'd5, 0,0,0,0,0,3'd0}, // R1 idle
    '{1,0,0,12'h000,3'd5, 0,0,0,0,0,3'd0}, // R2 trigger
    '{0,0,1,12'h111,3'd5, 0,0,0,0,1,3'd0}, // R2 armed, no write; R3
    '{0,0,1,12'hABC,3'd5, 1,0,0,0,0,3'd0}, // R4 R5
    '{0,0,0,12'h222,3'd5, 0,0,0,0,1,3'd1}, // R4 gap
    '{0,0,1,12'h333,3'd5, 1,0,0,0,0,3'd1},
    '{0,0,1,12'h444,3'd5, 1,0,0,0,1,3'd2},
    '{0,0,1,12'h555,3'd5, 1,0,0,0,0,3'd3},
    '{0,0,1,12'h666,3'd5, 1,0,0,0,1,3'd4},
    '{0,0,1,12'h777,3'd5, 1,0,0,0,0,3'd5},
    '{0,0,1,12'h888,3'd5, 1,0,0,0,1,3'd6},
    '{0,0,1,12'hFFF,3'd5, 1,0,0,0,0,3'd7}, // R6 top word
    '{0,0,1,12'h123,3'd5, 0,1,1,1,0,3'd5}, // R6 R7
    '{1,0,0,12'h000,3'd2, 0,1,0,1,0,3'd2}, // R8 trigger ignored
    '{1,1,0,12'h000,3'd3, 0,1,0,1,0,3'd3}, // R8 release+trigger
    '{0,0,0,12'h000,3'd6, 0,0,0,0,0,3'd0}, // R8 idle, not armed
    '{0,1,0,12'h000,3'd6, 0,0,0,0,0,3'd0}, // R10 release in idle
    '{1,0,0,12'h000,3'd6, 0,0,0,0,0,3'd0}, // R2
    '{0,0,1,12'h0AA,3'd6, 0,0,0,0,1,3'd0},
    '{0,0,1,12'h0BB,3'd6, 1,0,0,0,0,3'd0},
    '{0,1,1,12'h0CC,3'd6, 1,0,0,0,1,3'd1}, // R10 release while sampling
    '{1,0,1,12'h0DD,3'd6, 1,0,0,0,0,3'd2}, // R9 trigger + valid
    '{0,0,1,12'h0EE,3'd6, 0,0,0,0,1,3'd0}, // R9 re-armed at 0
    '{0,0,1,12'h0FF,3'd6, 1,0,0,0,0,3'd0}  // R9 R5 restart at 0
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #2;
    chk("R1", "done", done, 0); chk("R1", "irq", irq, 0);
    chk("R1", "hoe", hoe, 0); chk("R1", "ce", ce, 0);
    chk("R1", "addr", addr, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      trig = VEC[i].tr; rel = VEC[i].rl; vld = VEC[i].vl;
      data = VEC[i].dt; haddr = VEC[i].ha;
      #2;
      chk($sformatf("vec%0d", i), "we", we, VEC[i].we);
      chk($sformatf("vec%0d", i), "done", done, VEC[i].dn);
      chk($sformatf("vec%0d", i), "irq", irq, VEC[i].iq);
      chk($sformatf("vec%0d", i), "hoe", hoe, VEC[i].oe);
      chk($sformatf("vec%0d", i), "ce", ce, VEC[i].ce);
      chk($sformatf("vec%0d", i), "addr", addr, VEC[i].ad);
      chk("R4", "wdata", wd, {4'h0, VEC[i].dt});
    end
    // R1: asynchronous reset in the middle of a round
    @(negedge clk); trig = 0; rel = 0; vld = 1; data = 12'h5A5;
    @(negedge clk); #2;
    chk("R5", "addr mid", addr, 2);
    rst_n = 1'b0; #1;
    chk("R1", "we rst", we, 0); chk("R1", "addr rst", addr, 0);
    chk("R1", "ce rst", ce, 0); chk("R1", "done rst", done, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1", "idle after rst", we, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule